// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block is the command interpreter inside a parallel NOR flash that runs in word mode. It watches host write cycles, each made of an address and a data word, and recognises the unlock prefix and the command byte that follows. From these it steps through read-array, identification, query, program, whole-chip erase, sector erase, collection window, erase-suspended and resumed states. For the program/erase engine it drives a mode code, a one-cycle start pulse with an operation code, the program address and data, and a bitmap of the sectors chosen for erase. A behavioural countdown stands in for the time the array operation takes.

Writes are sampled on the rising clock. One clock with chip enable and write enable low and output enable high is one bus write. Only data bits [7:0] and address bits [10:0] take part in command matching. The sector of an address is its top `SECT_W` bits.

States: `ST_READ` (idle array reads), `ST_UNL1` (first unlock seen), `ST_UNL2` (second unlock seen, command expected), `ST_PROG_ARM` (program armed), `ST_ERS1` (erase setup seen), `ST_ERS2` and `ST_ERS3` (second unlock pair), `ST_AUTOSEL` (identification), `ST_CFI` (query), `ST_PROG_BUSY`, `ST_CHIP_BUSY`, `ST_SECT_WIN` (collection window), `ST_SECT_BUSY` and `ST_SUSP`. The transitions are:
- READ→UNL1 on AA/555, and READ→CFI on 98/055.
- UNL1→UNL2 on 55/2AA.
- UNL2 goes to PROG_ARM on A0/555, to ERS1 on 80/555, or to AUTOSEL on 90/555.
- PROG_ARM→PROG_BUSY on any write.
- ERS1→ERS2 on AA/555, and ERS2→ERS3 on 55/2AA.
- ERS3 goes to CHIP_BUSY on 10/555, or to SECT_WIN on 30 at any address.
- SECT_WIN→SECT_BUSY when the window expires.
- SECT_BUSY→SUSP on B0, and SUSP→SECT_BUSY on 30.
- AUTOSEL→CFI on 98/055.
- The busy states return to READ when the timer finishes. AUTOSEL and CFI return to READ on F0.
- Any mismatch in UNL1, UNL2 or ERS1–ERS3 goes to READ.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, mode_o is 0 (read array), busy, eng_start and sect_map are 0, and no partial sequence is held.
- R2: The writes AA@555, 55@2AA, A0@555 and then one further write at any address with any data (F0 included) give one eng_start pulse in the cycle after that last write. With the pulse, eng_op is 1, eng_addr and eng_data hold that write's address and data, and mode_o is 3.
- R3: The writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 start a chip erase: eng_start pulses with eng_op 2 and mode_o is 4. A B0 write during a chip erase has no effect.
- R4: The same five-write prefix followed by 30 at any address enters the collection window (mode_o 5). sect_map then holds only that sector's bit (bit i is sector i). Each further 30 write in the window sets its sector's bit and restarts the window. Other writes in the window are ignored.
- R5: The window expires WIN_CYC cycles after the last 30 write. In that cycle eng_start pulses with eng_op 3, mode_o becomes 6, and sect_map holds the collected set.
- R6: B0 during a sector erase enters suspend (mode_o 7, busy 0) and freezes the erase timer. Only a 30 write resumes, back to mode_o 6. A 30 write in read-array mode does nothing.
- R7: F0 at any address returns to read array from any partial unlock or erase prefix, from identification and from query.
- R8: While a program or chip erase is running, every write is ignored, and no command sequence is started by the writes made during that time.
- R9: busy is high for exactly PROG_CYC cycles for a program, CERASE_CYC cycles for a chip erase, and SERASE_CYC non-suspended cycles for a sector erase. Then mode_o returns to 0 and sect_map clears.
- R10: A write with the wrong data or the wrong address partway through a prefix drops the prefix and returns to read array without a start. Writes that would have completed the sequence then have no effect.
- R11: 98 at address 055 from read array (or from identification) gives mode_o 2. 98 at any other address does nothing.
- R12: AA@555, 55@2AA, 90@555 gives mode_o 1 (identification).
- R13: A clock with any strobe pattern other than ce_n=0, we_n=0, oe_n=1 is not a write. It neither advances nor breaks a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Write address |
| wdata | input | 16 | Write data |
| mode_o | output | 3 | Mode: 0 read, 1 ident, 2 query, 3 program, 4 chip erase, 5 window, 6 sector erase, 7 suspended |
| eng_start | output | 1 | One-cycle engine start |
| eng_op | output | 2 | Operation with start: 1 program, 2 chip erase, 3 sector erase |
| eng_addr | output | ADDR_W | Program address |
| eng_data | output | 16 | Program data |
| sect_map | output | 2**SECT_W | Sectors selected for erase |
| busy | output | 1 | Engine running |

## Verification
The program path is tried with address and data at all-zero, all-one, on the unlock addresses and with an F0 data word. This separates "any write is data" from command matching. The sector window is swept over all fifteen non-empty sector sets, with gaps longer than half the window, so that restart, bit order and expiry timing are each pinned down. Prefix aborts are swept position by position, with wrong data, with a wrong address and with F0, and each abort is followed by the completing writes to show nothing was kept. Every blocked strobe pattern is tried both at the start of a sequence and on a program data write.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PROG_ARM,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3,
        ST_AUTOSEL,
        ST_CFI,
        ST_PROG_BUSY,
        ST_CHIP_BUSY,
        ST_SECT_WIN,
        ST_SECT_BUSY,
        ST_SUSP
    } state_t;

    typedef enum logic [2:0] {
        MD_READ    = 3'd0,
        MD_AUTOSEL = 3'd1,
        MD_CFI     = 3'd2,
        MD_PROG    = 3'd3,
        MD_CHIP    = 3'd4,
        MD_WIN     = 3'd5,
        MD_SECT    = 3'd6,
        MD_SUSP    = 3'd7
    } mode_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_CHIP = 2'd2,
        OP_SECT = 2'd3
    } op_t;

    localparam logic [10:0] ADR_KEY1  = 11'h555;
    localparam logic [10:0] ADR_KEY2  = 11'h2AA;
    localparam logic [10:0] ADR_QUERY = 11'h055;

    localparam logic [7:0] CD_KEY1  = 8'hAA;
    localparam logic [7:0] CD_KEY2  = 8'h55;
    localparam logic [7:0] CD_PROG  = 8'hA0;
    localparam logic [7:0] CD_ESET  = 8'h80;
    localparam logic [7:0] CD_IDENT = 8'h90;
    localparam logic [7:0] CD_CHIP  = 8'h10;
    localparam logic [7:0] CD_SECT  = 8'h30;
    localparam logic [7:0] CD_SUSP  = 8'hB0;
    localparam logic [7:0] CD_QUERY = 8'h98;
    localparam logic [7:0] CD_EXIT  = 8'hF0;

    // decoded view of one bus clock
    typedef struct packed {
        logic wr;
        logic exit_any;
        logic key1;
        logic key2;
        logic prog_cmd;
        logic eset_cmd;
        logic ident_cmd;
        logic chip_cmd;
        logic sect_any;
        logic susp_any;
        logic query_cmd;
    } cmd_t;

endpackage

// File: rtl/nor_bus_qual.sv
module nor_bus_qual
    import nor_cmd_pkg::*;
(
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [10:0] addr_lo,
    input  logic [7:0]  data_lo,
    output cmd_t        cmd
);

    logic wr;
    logic at_k1;
    logic at_k2;
    logic at_q;

    assign wr    = !ce_n && !we_n && oe_n;
    assign at_k1 = (addr_lo == ADR_KEY1);
    assign at_k2 = (addr_lo == ADR_KEY2);
    assign at_q  = (addr_lo == ADR_QUERY);

    always_comb begin
        cmd           = '0;
        cmd.wr        = wr;
        cmd.exit_any  = wr && (data_lo == CD_EXIT);
        cmd.key1      = wr && at_k1 && (data_lo == CD_KEY1);
        cmd.key2      = wr && at_k2 && (data_lo == CD_KEY2);
        cmd.prog_cmd  = wr && at_k1 && (data_lo == CD_PROG);
        cmd.eset_cmd  = wr && at_k1 && (data_lo == CD_ESET);
        cmd.ident_cmd = wr && at_k1 && (data_lo == CD_IDENT);
        cmd.chip_cmd  = wr && at_k1 && (data_lo == CD_CHIP);
        cmd.sect_any  = wr && (data_lo == CD_SECT);
        cmd.susp_any  = wr && (data_lo == CD_SUSP);
        cmd.query_cmd = wr && at_q && (data_lo == CD_QUERY);
    end

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = run && !load && (cnt == CNT_W'(1));

endmodule

// File: rtl/nor_sector_set.sv
module nor_sector_set #(
    parameter int SECT_W = 2,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first,
    input  logic              add,
    input  logic              clr,
    input  logic [SECT_W-1:0] idx,
    output logic [NSECT-1:0]  map
);

    logic [NSECT-1:0] hit;

    for (genvar i = 0; i < NSECT; i++) begin : g_hit
        assign hit[i] = (idx == SECT_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map <= '0;
        end else if (first) begin
            map <= hit;
        end else if (add) begin
            map <= map | hit;
        end else if (clr) begin
            map <= '0;
        end
    end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int SECT_W     = 2,
    parameter int PROG_CYC   = 6,
    parameter int CERASE_CYC = 24,
    parameter int SERASE_CYC = 16,
    parameter int WIN_CYC    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ce_n,
    input  logic                     we_n,
    input  logic                     oe_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [15:0]              wdata,
    output logic [2:0]               mode_o,
    output logic                     eng_start,
    output logic [1:0]               eng_op,
    output logic [ADDR_W-1:0]        eng_addr,
    output logic [15:0]              eng_data,
    output logic [(1<<SECT_W)-1:0]   sect_map,
    output logic                     busy
);

    localparam int MAX_A = (PROG_CYC > CERASE_CYC) ? PROG_CYC : CERASE_CYC;
    localparam int MAX_B = (MAX_A > SERASE_CYC) ? MAX_A : SERASE_CYC;
    localparam int ENG_W = $clog2(MAX_B + 1);
    localparam int WIN_W = $clog2(WIN_CYC + 1);

    state_t st;
    state_t nxt;
    cmd_t   c;

    logic             launch;
    op_t              launch_op;
    logic             win_load;
    logic             sect_first;
    logic             sect_add;
    logic             sect_clr;
    logic             eng_run;
    logic             eng_done;
    logic             win_run;
    logic             win_done;
    logic [ENG_W-1:0] eng_len;

    nor_bus_qual u_qual (
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr_lo (addr[10:0]),
        .data_lo (wdata[7:0]),
        .cmd     (c)
    );

    // next state and side actions
    always_comb begin
        nxt        = st;
        launch     = 1'b0;
        launch_op  = OP_NONE;
        win_load   = 1'b0;
        sect_first = 1'b0;
        sect_add   = 1'b0;
        sect_clr   = 1'b0;
        unique case (st)
            ST_READ: begin
                if (c.key1)           nxt = ST_UNL1;
                else if (c.query_cmd) nxt = ST_CFI;
            end
            ST_UNL1: begin
                if (c.wr) nxt = c.key2 ? ST_UNL2 : ST_READ;
            end
            ST_UNL2: begin
                if (c.prog_cmd)       nxt = ST_PROG_ARM;
                else if (c.eset_cmd)  nxt = ST_ERS1;
                else if (c.ident_cmd) nxt = ST_AUTOSEL;
                else if (c.wr)        nxt = ST_READ;
            end
            ST_PROG_ARM: begin
                if (c.wr) begin
                    nxt       = ST_PROG_BUSY;
                    launch    = 1'b1;
                    launch_op = OP_PROG;
                end
            end
            ST_ERS1: begin
                if (c.wr) nxt = c.key1 ? ST_ERS2 : ST_READ;
            end
            ST_ERS2: begin
                if (c.wr) nxt = c.key2 ? ST_ERS3 : ST_READ;
            end
            ST_ERS3: begin
                if (c.chip_cmd) begin
                    nxt       = ST_CHIP_BUSY;
                    launch    = 1'b1;
                    launch_op = OP_CHIP;
                end else if (c.sect_any) begin
                    nxt        = ST_SECT_WIN;
                    win_load   = 1'b1;
                    sect_first = 1'b1;
                end else if (c.wr) begin
                    nxt = ST_READ;
                end
            end
            ST_AUTOSEL: begin
                if (c.exit_any)       nxt = ST_READ;
                else if (c.query_cmd) nxt = ST_CFI;
            end
            ST_CFI: begin
                if (c.exit_any) nxt = ST_READ;
            end
            ST_PROG_BUSY, ST_CHIP_BUSY: begin
                if (eng_done) nxt = ST_READ;
            end
            ST_SECT_WIN: begin
                if (c.sect_any) begin
                    win_load = 1'b1;
                    sect_add = 1'b1;
                end else if (win_done) begin
                    nxt       = ST_SECT_BUSY;
                    launch    = 1'b1;
                    launch_op = OP_SECT;
                end
            end
            ST_SECT_BUSY: begin
                if (eng_done) begin
                    nxt      = ST_READ;
                    sect_clr = 1'b1;
                end else if (c.susp_any) begin
                    nxt = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (c.sect_any) nxt = ST_SECT_BUSY;
            end
            default: nxt = ST_READ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_READ;
        else        st <= nxt;
    end

    // outputs decoded from state
    always_comb begin
        unique case (st)
            ST_AUTOSEL:   mode_o = MD_AUTOSEL;
            ST_CFI:       mode_o = MD_CFI;
            ST_PROG_BUSY: mode_o = MD_PROG;
            ST_CHIP_BUSY: mode_o = MD_CHIP;
            ST_SECT_WIN:  mode_o = MD_WIN;
            ST_SECT_BUSY: mode_o = MD_SECT;
            ST_SUSP:      mode_o = MD_SUSP;
            default:      mode_o = MD_READ;
        endcase
    end

    assign eng_run = (st == ST_PROG_BUSY) || (st == ST_CHIP_BUSY) || (st == ST_SECT_BUSY);
    assign win_run = (st == ST_SECT_WIN);
    assign busy    = eng_run;

    always_comb begin
        unique case (launch_op)
            OP_PROG: eng_len = ENG_W'(PROG_CYC);
            OP_CHIP: eng_len = ENG_W'(CERASE_CYC);
            OP_SECT: eng_len = ENG_W'(SERASE_CYC);
            default: eng_len = '0;
        endcase
    end

    // start pulse and program operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_start <= 1'b0;
            eng_op    <= OP_NONE;
            eng_addr  <= '0;
            eng_data  <= '0;
        end else begin
            eng_start <= launch;
            eng_op    <= launch ? launch_op : OP_NONE;
            if (launch && (launch_op == OP_PROG)) begin
                eng_addr <= addr;
                eng_data <= wdata;
            end
        end
    end

    nor_busy_timer #(.CNT_W(ENG_W)) u_eng_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (eng_len),
        .run      (eng_run),
        .done     (eng_done)
    );

    nor_busy_timer #(.CNT_W(WIN_W)) u_win_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (WIN_W'(WIN_CYC)),
        .run      (win_run),
        .done     (win_done)
    );

    nor_sector_set #(.SECT_W(SECT_W)) u_sect (
        .clk   (clk),
        .rst_n (rst_n),
        .first (sect_first),
        .add   (sect_add),
        .clr   (sect_clr),
        .idx   (addr[ADDR_W-1 -: SECT_W]),
        .map   (sect_map)
    );

endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
    parameter int MAP_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             we_n,
    input logic             oe_n,
    input logic [7:0]       wdata_lo,
    input logic [2:0]       mode_o,
    input logic             eng_start,
    input logic             busy,
    input logic [MAP_W-1:0] sect_map
);

    logic wr;
    assign wr = !ce_n && !we_n && oe_n;

    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    p_chip_no_susp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) |=> (mode_o == 3'd4 || mode_o == 3'd0));

    p_map_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd5 || mode_o == 3'd6 || mode_o == 3'd7) |-> (sect_map != '0));

    p_window_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd6 && $past(mode_o) == 3'd5) |-> eng_start);

    p_susp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd7 && !(wr && wdata_lo == 8'h30)) |=> (mode_o == 3'd7 && !busy));

    p_busy_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mode_o == 3'd3 || mode_o == 3'd4 || mode_o == 3'd6));

    p_idle_no_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 3'd0 || mode_o == 3'd1 || mode_o == 3'd2) && !wr) |=> !eng_start);

endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.MAP_W(1 << SECT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .wdata_lo  (wdata[7:0]),
    .mode_o    (mode_o),
    .eng_start (eng_start),
    .busy      (busy),
    .sect_map  (sect_map)
);

// File: tb/nor_cmd_decoder_tb.sv
module nor_cmd_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int SECT_W     = 2;
    localparam int NSECT      = 1 << SECT_W;
    localparam int PROG_CYC   = 6;
    localparam int CERASE_CYC = 24;
    localparam int SERASE_CYC = 16;
    localparam int WIN_CYC    = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1;
    logic              we_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       wdata = '0;
    logic [2:0]        mode_o;
    logic              eng_start;
    logic [1:0]        eng_op;
    logic [ADDR_W-1:0] eng_addr;
    logic [15:0]       eng_data;
    logic [NSECT-1:0]  sect_map;
    logic              busy;

    int n_chk  = 0;
    int n_fail = 0;
    int n_start = 0;
    int n_sect  = 0;
    logic done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_decoder #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
        .CERASE_CYC(CERASE_CYC), .SERASE_CYC(SERASE_CYC), .WIN_CYC(WIN_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .mode_o(mode_o), .eng_start(eng_start),
        .eng_op(eng_op), .eng_addr(eng_addr), .eng_data(eng_data),
        .sect_map(sect_map), .busy(busy)
    );

    always @(posedge clk) begin
        if (rst_n && eng_start) n_start++;
        if (rst_n && mode_o == 3'd6) n_sect++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // one bus clock with the given {ce_n,we_n,oe_n}; called at a falling edge
    task automatic wrs(input logic [11:0] a, input logic [15:0] d, input logic [2:0] s);
        addr = a;
        wdata = d;
        {ce_n, we_n, oe_n} = s;
        @(negedge clk);
        {ce_n, we_n, oe_n} = 3'b111;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        wrs(a, d, 3'b001);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_read();
        for (int i = 0; i < 200; i++) begin
            if (mode_o == 3'd0) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [11:0] seq_a(input int i);
        case (i)
            0, 2, 3: seq_a = 12'h555;
            default: seq_a = 12'h2AA;
        endcase
    endfunction

    function automatic logic [7:0] seq_d(input int i);
        case (i)
            0, 3:    seq_d = 8'hAA;
            1, 4:    seq_d = 8'h55;
            default: seq_d = 8'h80;
        endcase
    endfunction

    task automatic erase_prefix();
        for (int j = 0; j < 5; j++) wr(seq_a(j), {8'h00, seq_d(j)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int s0;
        int first;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 mode", mode_o, 0);
        chk("R1 busy", busy, 0);
        chk("R1 start", eng_start, 0);
        chk("R1 map", sect_map, 0);

        // R2 / R9 program sweep
        for (int p = 0; p < 4; p++) begin
            logic [11:0] pa;
            logic [15:0] pd;
            case (p)
                0: begin pa = 12'h000; pd = 16'h0000; end
                1: begin pa = 12'hFFF; pd = 16'hFFFF; end
                2: begin pa = 12'h555; pd = 16'hA5A5; end
                default: begin pa = 12'h2AA; pd = 16'h00F0; end
            endcase
            wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'hA0);
            wr(pa, pd);
            chk("R2 start", eng_start, 1);
            chk("R2 op", eng_op, 1);
            chk("R2 addr", eng_addr, pa);
            chk("R2 data", eng_data, pd);
            chk("R2 mode", mode_o, 3);
            idle(PROG_CYC - 1);
            chk("R9 prog busy end", busy, 1);
            idle(1);
            chk("R9 prog done", {busy, mode_o}, 0);
        end

        // R8 writes ignored during a program
        wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'hA0);
        wr(12'h100, 16'h1234);
        s0 = n_start;
        wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'hA0);
        chk("R8 mode during", mode_o, 3);
        idle(PROG_CYC - 4);
        chk("R8 still prog", mode_o, 3);
        idle(1);
        chk("R8 back to read", mode_o, 0);
        wr(12'h200, 16'h4321);
        idle(1);
        chk("R8 no start", n_start - s0, 1);  // only the pulse of the launch itself
        chk("R8 mode after", mode_o, 0);

        // R3 chip erase, suspend ignored
        erase_prefix();
        wr(12'h555, 16'h10);
        chk("R3 start", eng_start, 1);
        chk("R3 op", eng_op, 2);
        chk("R3 mode", mode_o, 4);
        wr(12'h000, 16'hB0);
        chk("R3 B0 ignored", mode_o, 4);
        idle(CERASE_CYC - 2);
        chk("R9 chip busy end", busy, 1);
        idle(1);
        chk("R9 chip done", mode_o, 0);

        // R4 / R5 / R9 sector set sweep
        for (int m = 1; m < NSECT * 2 * 2; m++) begin
            if (m >= (1 << NSECT)) break;
            first = 1;
            for (int s = 0; s < NSECT; s++) begin
                if (m[s]) begin
                    if (first) begin
                        erase_prefix();
                        wr(12'(s << (ADDR_W - SECT_W)) | 12'h00F, 16'h30);
                        chk("R4 first map", sect_map, 1 << s);
                        chk("R4 window mode", mode_o, 5);
                        first = 0;
                    end else begin
                        idle(WIN_CYC - 2);
                        if (m == 5) begin
                            wr(12'h000, 16'hF0);
                            chk("R4 F0 ignored in window", mode_o, 5);
                        end
                        wr(12'(s << (ADDR_W - SECT_W)), 16'h0030);
                        chk("R4 add mode", mode_o, 5);
                    end
                end
            end
            idle(WIN_CYC - 1);
            chk("R5 before expiry", {eng_start, mode_o}, 5);
            n_sect = 0;
            idle(1);
            chk("R5 start", eng_start, 1);
            chk("R5 op", eng_op, 3);
            chk("R5 mode", mode_o, 6);
            chk("R5 map", sect_map, m);
            wait_read();
            chk("R9 sector cycles", n_sect, SERASE_CYC);
            chk("R9 map cleared", sect_map, 0);
        end

        // R6 suspend and resume
        erase_prefix();
        wr(12'h400, 16'h30);
        idle(WIN_CYC);
        n_sect = 0;
        chk("R6 erasing", mode_o, 6);
        idle(4);
        wr(12'h000, 16'hB0);
        chk("R6 suspended", mode_o, 7);
        chk("R6 not busy", busy, 0);
        idle(10);
        wr(12'h7FF, 16'hF0);
        chk("R6 holds suspend", mode_o, 7);
        wr(12'h123, 16'h30);
        chk("R6 resumed", mode_o, 6);
        wait_read();
        chk("R6 total erase cycles", n_sect, SERASE_CYC);
        s0 = n_start;
        wr(12'h400, 16'h30);
        idle(1);
        chk("R6 resume in read ignored", {n_start - s0, 32'(mode_o)}, 0);

        // R10 mismatch sweep
        for (int k = 1; k <= 5; k++) begin
            for (int v = 0; v < 2; v++) begin
                if (k == 5 && v == 1) continue;
                s0 = n_start;
                for (int j = 0; j < k; j++) wr(seq_a(j), {8'h00, seq_d(j)});
                if (k == 5)      wr(12'h400, 16'h11);
                else if (v == 0) wr(seq_a(k), 16'h11);
                else             wr(12'h123, {8'h00, seq_d(k)});
                chk("R10 abort mode", mode_o, 0);
                wr(12'h555, 16'h10);
                wr(12'h400, 16'h30);
                idle(1);
                chk("R10 nothing started", {n_start - s0, 32'(mode_o)}, 0);
            end
        end

        // R7 F0 from each prefix
        for (int k = 1; k <= 5; k++) begin
            s0 = n_start;
            for (int j = 0; j < k; j++) wr(seq_a(j), {8'h00, seq_d(j)});
            wr(12'h7FF, 16'hF0);
            chk("R7 exit mode", mode_o, 0);
            wr(12'h555, 16'h10);
            idle(1);
            chk("R7 nothing started", {n_start - s0, 32'(mode_o)}, 0);
        end

        // R11 query
        wr(12'h056, 16'h98);
        chk("R11 wrong addr", mode_o, 0);
        wr(12'h055, 16'h98);
        chk("R11 query", mode_o, 2);
        wr(12'h555, 16'hAA);
        chk("R11 holds", mode_o, 2);
        wr(12'h000, 16'hF0);
        chk("R7 exit query", mode_o, 0);

        // R12 identification
        wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'h90);
        chk("R12 ident", mode_o, 1);
        wr(12'h055, 16'h98);
        chk("R11 query from ident", mode_o, 2);
        wr(12'h000, 16'hF0);
        wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'h90);
        wr(12'h3FF, 16'hF0);
        chk("R7 exit ident", mode_o, 0);

        // R13 strobe patterns
        for (int c = 0; c < 8; c++) begin
            if (c == 1) continue;
            wrs(12'h555, 16'hAA, 3'(c));
            wr(12'h2AA, 16'h55); wr(12'h555, 16'h90);
            chk("R13 blocked first write", mode_o, 0);
            wr(12'h555, 16'hAA); wr(12'h2AA, 16'h55); wr(12'h555, 16'hA0);
            wrs(12'h111, 16'h2222, 3'(c));
            chk("R13 blocked data", eng_start, 0);
            wr(12'h333, 16'h4444);
            chk("R13 still armed", eng_start, 1);
            chk("R13 operand", eng_addr, 12'h333);
            wait_read();
        end

        summary();
    end

endmodule